// File: doc/BRIEF.md
# SCSI Initiator Register and Command Front End

This block is the byte-wide register file and command decoder of a small SCSI initiator controller. A host reaches sixteen byte registers through a 4-bit address with separate read and write strobes. It can set a 16-bit transfer count, the source and destination IDs, a sync-parameters byte and a selection timeout. It can also stream bytes through a small FIFO, and it reads back a fixed chip identifier, the live bus lines, and exception, error and interrupt status.

A byte written to the sequence register is a command. Its low nibble selects an operation and bit 7 marks it as a DMA command. The front end updates its own status bits at once. For the phase operations it passes a one-cycle request, with the operation, the byte length, the ATN flag and the DMA flag, to the bus-phase sequencer that sits beside it. The sequencer reports back through three pulse inputs: done, selection timeout and arbitration lost. A level interrupt is raised while any unmasked status bit is set.

Top module: `scsi_rf_front`

## Requirements
- R1: After reset every register reads zero, except three: the source ID reads 7, the sync-parameters byte reads 0x02 and the chip-ID register (address 0xE) reads the CHIP_ID parameter. `irq` is low.
- R2: Registers 0 and 1 read back the low and high bytes of the transfer count as written. The source ID (0xB, 3 bits), destination ID (0xC, 3 bits), sync parameters (0xD) and selection timeout (0xF) also read back as written.
- R3: Writing address 2 pushes a byte and reading it pops a byte, in first-in first-out order. Address 6 reads the fill count. A push to a full FIFO or a pop from an empty one changes nothing in the FIFO. The pop returns 0 in that case. Such a push sets error bit 0 (address 8) and such a pop sets error bit 1. Either one also sets interrupt-status bit 2.
- R4: A write to address 3 stores the byte (it reads back at address 3) and clears interrupt-status bit 0. For codes 1 to 8, one cycle later `seq_req` pulses for one cycle with `seq_op` equal to the low nibble and `seq_dma` equal to bit 7. `seq_atn` equals bit 5 for code 2 and is 0 otherwise. `dma_req` pulses only for codes 5 and 6 with bit 7 set.
- R5: For codes 5 (data-out) and 6 (data-in) a transfer count of 0 gives `seq_len` = 65536. Every other requesting code passes the count unchanged, zero included.
- R6: Code 1 clears exception bit 2 and code 2 clears exception bit 0. A `seq_arblost` pulse sets exception bit 2 and a `seq_selto` pulse sets exception bit 0. Either pulse also sets interrupt-status bit 1. A `seq_done` pulse sets interrupt-status bit 0.
- R7: Code 9 pulses `ack_release` one cycle later. If BSY (`bus_sense` bit 13) is high, it sets exception bit 1 and interrupt-status bit 1. If BSY is low, it sets interrupt-status bit 0. It sends no sequencer request.
- R8: Code 0xE does the following: the command register returns to 0; the FIFO, interrupt mask, exception, error and transfer count are cleared; the source ID is set to 7; interrupt-status bit 0 is set. The sync parameters, destination ID and selection timeout keep their values.
- R9: Code 0xF empties the FIFO and sets interrupt-status bit 0.
- R10: `irq` is high exactly when (interrupt status AND interrupt mask at address 9) is nonzero. Writing 1 to a bit of the interrupt status (address 0xA) clears that bit.
- R11: Codes 0xA/0xB set/clear `parity_en` and codes 0xC/0xD set/clear `resel_en`. Each of them sets interrupt-status bit 0.
- R12: Code 3 requests the sequencer only when the FIFO holds at least one byte. It never sets interrupt-status bit 0 by itself.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | 4 | Register address |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe (pops the FIFO at address 2) |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, combinational from `addr` |
| bus_sense | input | 16 | Sensed bus lines; bit 13 is BSY |
| seq_done | input | 1 | Sequencer step finished |
| seq_selto | input | 1 | Sequencer reports selection timeout |
| seq_arblost | input | 1 | Sequencer reports arbitration lost |
| seq_req | output | 1 | One-cycle request to the sequencer |
| seq_op | output | 4 | Requested operation code |
| seq_len | output | 17 | Bytes to transfer |
| seq_atn | output | 1 | Assert ATN during selection |
| seq_dma | output | 1 | Command marked as DMA |
| dma_req | output | 1 | DMA request strobe for data phases |
| ack_release | output | 1 | Release ACK pulse (bus-free command) |
| parity_en | output | 1 | Parity checking enabled |
| resel_en | output | 1 | Reselection enabled |
| irq | output | 1 | Level interrupt |

## Verification
The bench builds the block with FIFO_DEPTH = 8 and CHIP_ID = 0xC3. The shallower FIFO makes both the full and the empty boundary reachable within a few writes. A non-default chip ID shows that the identifier register follows the parameter. The bench model recomputes the interrupt level on every clock. It checks every command write for the request, the length (including the zero-count cases), the ATN and DMA flags and the ACK release.

// File: rtl/scsi_rf_pkg.sv
package scsi_rf_pkg;

  typedef enum logic [3:0] {
    OP_NOP     = 4'h0,
    OP_ARB     = 4'h1,
    OP_SEL     = 4'h2,
    OP_CMD     = 4'h3,
    OP_STAT    = 4'h4,
    OP_DOUT    = 4'h5,
    OP_DIN     = 4'h6,
    OP_MOUT    = 4'h7,
    OP_MIN     = 4'h8,
    OP_BFREE   = 4'h9,
    OP_PAR_ON  = 4'hA,
    OP_PAR_OFF = 4'hB,
    OP_RSL_ON  = 4'hC,
    OP_RSL_OFF = 4'hD,
    OP_SRST    = 4'hE,
    OP_FLUSH   = 4'hF
  } op_e;

  localparam logic [3:0] A_CNT_LO = 4'h0;
  localparam logic [3:0] A_CNT_HI = 4'h1;
  localparam logic [3:0] A_FIFO   = 4'h2;
  localparam logic [3:0] A_SEQ    = 4'h3;
  localparam logic [3:0] A_BUS_LO = 4'h4;
  localparam logic [3:0] A_BUS_HI = 4'h5;
  localparam logic [3:0] A_FCOUNT = 4'h6;
  localparam logic [3:0] A_EXC    = 4'h7;
  localparam logic [3:0] A_ERR    = 4'h8;
  localparam logic [3:0] A_MASK   = 4'h9;
  localparam logic [3:0] A_ISTAT  = 4'hA;
  localparam logic [3:0] A_SRC    = 4'hB;
  localparam logic [3:0] A_DST    = 4'hC;
  localparam logic [3:0] A_SYNC   = 4'hD;
  localparam logic [3:0] A_CHIP   = 4'hE;
  localparam logic [3:0] A_SELTO  = 4'hF;

  localparam int IS_DONE  = 0;
  localparam int IS_EXC   = 1;
  localparam int IS_ERR   = 2;
  localparam int EX_SELTO = 0;
  localparam int EX_PHASE = 1;
  localparam int EX_ARB   = 2;
  localparam int ER_OVF   = 0;
  localparam int ER_UDF   = 1;
  localparam int BSY_BIT  = 13;

  typedef struct packed {
    logic       req;
    logic [2:0] exc_clr;
    logic       busfree;
    logic       srst;
    logic       flush;
    logic       par_on;
    logic       par_off;
    logic       rsl_on;
    logic       rsl_off;
    logic       done;
  } dec_t;

  // Data phases treat a zero count as the full 64 KiB window.
  function automatic logic [16:0] phase_len(input op_e op, input logic [15:0] cnt);
    if ((op == OP_DIN || op == OP_DOUT) && cnt == 16'h0000)
      return 17'h10000;
    return {1'b0, cnt};
  endfunction

  function automatic logic irq_level(input logic [2:0] stat, input logic [2:0] mask);
    return |(stat & mask);
  endfunction

endpackage

// File: rtl/scsi_rf_fifo.sv
module scsi_rf_fifo #(
  parameter int DEPTH = 16,
  parameter int CW    = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          flush,
  input  logic          push_req,
  input  logic          pop_req,
  input  logic [7:0]    din,
  output logic [7:0]    dout,
  output logic [CW-1:0] count,
  output logic          empty,
  output logic          push_drop,
  output logic          pop_drop
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [7:0]    mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic          full, do_push, do_pop;

  assign full      = (count == CW'(DEPTH));
  assign empty     = (count == '0);
  assign do_push   = push_req && !full;
  assign do_pop    = pop_req && !empty;
  assign push_drop = push_req && full;
  assign pop_drop  = pop_req && empty;
  assign dout      = empty ? 8'h00 : mem[rp];

  always_ff @(posedge clk) begin
    if (do_push && !flush) mem[wp] <= din;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp <= '0; rp <= '0; count <= '0;
    end else if (flush) begin
      wp <= '0; rp <= '0; count <= '0;
    end else begin
      if (do_push) wp <= (wp == AW'(DEPTH - 1)) ? '0 : wp + 1'b1;
      if (do_pop)  rp <= (rp == AW'(DEPTH - 1)) ? '0 : rp + 1'b1;
      if (do_push && !do_pop)      count <= count + 1'b1;
      else if (do_pop && !do_push) count <= count - 1'b1;
    end
  end

  p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CW'(DEPTH));

  p_drop_keeps_count_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (push_req && full && !pop_req && !flush) |=> $stable(count));

  p_empty_pop_keeps_count_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (pop_req && empty && !push_req && !flush) |=> (count == '0));
endmodule

// File: rtl/scsi_rf_decode.sv
module scsi_rf_decode
  import scsi_rf_pkg::*;
(
  input  op_e  op,
  input  logic fifo_empty,
  output dec_t dec
);
  always_comb begin
    dec = '0;
    case (op)
      OP_ARB:     begin dec.req = 1'b1; dec.exc_clr[EX_ARB] = 1'b1; end
      OP_SEL:     begin dec.req = 1'b1; dec.exc_clr[EX_SELTO] = 1'b1; end
      OP_CMD:     dec.req = !fifo_empty;
      OP_STAT,
      OP_DOUT,
      OP_DIN,
      OP_MOUT,
      OP_MIN:     dec.req = 1'b1;
      OP_BFREE:   dec.busfree = 1'b1;
      OP_PAR_ON:  begin dec.par_on  = 1'b1; dec.done = 1'b1; end
      OP_PAR_OFF: begin dec.par_off = 1'b1; dec.done = 1'b1; end
      OP_RSL_ON:  begin dec.rsl_on  = 1'b1; dec.done = 1'b1; end
      OP_RSL_OFF: begin dec.rsl_off = 1'b1; dec.done = 1'b1; end
      OP_SRST:    begin dec.srst  = 1'b1; dec.done = 1'b1; end
      OP_FLUSH:   begin dec.flush = 1'b1; dec.done = 1'b1; end
      default:    dec = '0;
    endcase
  end
endmodule

// File: rtl/scsi_rf_front.sv
module scsi_rf_front
  import scsi_rf_pkg::*;
#(
  parameter int         FIFO_DEPTH = 16,
  parameter logic [7:0] CHIP_ID    = 8'h5A
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [3:0]  addr,
  input  logic        wr_en,
  input  logic        rd_en,
  input  logic [7:0]  wdata,
  output logic [7:0]  rdata,
  input  logic [15:0] bus_sense,
  input  logic        seq_done,
  input  logic        seq_selto,
  input  logic        seq_arblost,
  output logic        seq_req,
  output logic [3:0]  seq_op,
  output logic [16:0] seq_len,
  output logic        seq_atn,
  output logic        seq_dma,
  output logic        dma_req,
  output logic        ack_release,
  output logic        parity_en,
  output logic        resel_en,
  output logic        irq
);
  localparam int FCW = $clog2(FIFO_DEPTH + 1);

  // Architectural registers
  logic [15:0] cnt_q;
  logic [7:0]  cmd_q, sync_q, selto_q;
  logic [2:0]  exc_q, mask_q, int_stat, src_q, dst_q;
  logic [1:0]  err_q;

  // Named internal events
  op_e            op;
  dec_t           dec;
  logic           cmd_wr, srst_ev, flush_ev, bsy;
  logic           ev_busfree_mm, ev_busfree_ok;
  logic           fifo_push, fifo_pop, push_drop, pop_drop, fifo_empty;
  logic [7:0]     fifo_dout;
  logic [FCW-1:0] fifo_cnt;
  logic [2:0]     stat_nxt, exc_nxt;
  logic [1:0]     err_nxt;

  assign op            = op_e'(wdata[3:0]);
  assign cmd_wr        = wr_en && (addr == A_SEQ);
  assign srst_ev       = cmd_wr && dec.srst;
  assign flush_ev      = cmd_wr && (dec.flush || dec.srst);
  assign bsy           = bus_sense[BSY_BIT];
  assign ev_busfree_mm = cmd_wr && dec.busfree && bsy;
  assign ev_busfree_ok = cmd_wr && dec.busfree && !bsy;
  assign fifo_push     = wr_en && (addr == A_FIFO);
  assign fifo_pop      = rd_en && (addr == A_FIFO);

  scsi_rf_decode u_dec (
    .op         (op),
    .fifo_empty (fifo_empty),
    .dec        (dec)
  );

  scsi_rf_fifo #(.DEPTH(FIFO_DEPTH), .CW(FCW)) u_fifo (
    .clk       (clk),
    .rst_n     (rst_n),
    .flush     (flush_ev),
    .push_req  (fifo_push),
    .pop_req   (fifo_pop),
    .din       (wdata),
    .dout      (fifo_dout),
    .count     (fifo_cnt),
    .empty     (fifo_empty),
    .push_drop (push_drop),
    .pop_drop  (pop_drop)
  );

  // Interrupt status: command clear first, then sets, then host W1C
  always_comb begin
    stat_nxt = int_stat;
    if (cmd_wr) stat_nxt[IS_DONE] = 1'b0;
    if (cmd_wr && (dec.done || ev_busfree_ok)) stat_nxt[IS_DONE] = 1'b1;
    if (seq_done) stat_nxt[IS_DONE] = 1'b1;
    if (ev_busfree_mm || seq_selto || seq_arblost) stat_nxt[IS_EXC] = 1'b1;
    if (push_drop || pop_drop) stat_nxt[IS_ERR] = 1'b1;
    if (wr_en && addr == A_ISTAT) stat_nxt = stat_nxt & ~wdata[2:0];
  end

  always_comb begin
    exc_nxt = exc_q;
    if (cmd_wr) exc_nxt = exc_nxt & ~dec.exc_clr;
    if (srst_ev) exc_nxt = '0;
    if (ev_busfree_mm) exc_nxt[EX_PHASE] = 1'b1;
    if (seq_selto)     exc_nxt[EX_SELTO] = 1'b1;
    if (seq_arblost)   exc_nxt[EX_ARB]   = 1'b1;
  end

  always_comb begin
    err_nxt = srst_ev ? 2'b00 : err_q;
    if (push_drop) err_nxt[ER_OVF] = 1'b1;
    if (pop_drop)  err_nxt[ER_UDF] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      int_stat <= '0;
      exc_q    <= '0;
      err_q    <= '0;
    end else begin
      int_stat <= stat_nxt;
      exc_q    <= exc_nxt;
      err_q    <= err_nxt;
    end
  end

  // Host-writable configuration
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      cmd_q   <= '0;
      mask_q  <= '0;
      src_q   <= 3'd7;
      dst_q   <= '0;
      sync_q  <= 8'h02;
      selto_q <= '0;
    end else if (srst_ev) begin
      cnt_q  <= '0;
      cmd_q  <= '0;
      mask_q <= '0;
      src_q  <= 3'd7;
    end else if (wr_en) begin
      case (addr)
        A_CNT_LO: cnt_q[7:0]  <= wdata;
        A_CNT_HI: cnt_q[15:8] <= wdata;
        A_SEQ:    cmd_q       <= wdata;
        A_MASK:   mask_q      <= wdata[2:0];
        A_SRC:    src_q       <= wdata[2:0];
        A_DST:    dst_q       <= wdata[2:0];
        A_SYNC:   sync_q      <= wdata;
        A_SELTO:  selto_q     <= wdata;
        default:  ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      parity_en <= 1'b0;
      resel_en  <= 1'b0;
    end else if (cmd_wr) begin
      if (dec.par_on)  parity_en <= 1'b1;
      if (dec.par_off) parity_en <= 1'b0;
      if (dec.rsl_on)  resel_en  <= 1'b1;
      if (dec.rsl_off) resel_en  <= 1'b0;
    end
  end

  // Sequencer request stage
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seq_req     <= 1'b0;
      seq_op      <= '0;
      seq_len     <= '0;
      seq_atn     <= 1'b0;
      seq_dma     <= 1'b0;
      dma_req     <= 1'b0;
      ack_release <= 1'b0;
    end else begin
      seq_req     <= cmd_wr && dec.req;
      dma_req     <= cmd_wr && dec.req && wdata[7] && (op == OP_DIN || op == OP_DOUT);
      ack_release <= cmd_wr && dec.busfree;
      if (cmd_wr && dec.req) begin
        seq_op  <= op;
        seq_len <= phase_len(op, cnt_q);
        seq_atn <= wdata[5] && (op == OP_SEL);
        seq_dma <= wdata[7];
      end
    end
  end

  assign irq = irq_level(int_stat, mask_q);

  always_comb begin
    case (addr)
      A_CNT_LO: rdata = cnt_q[7:0];
      A_CNT_HI: rdata = cnt_q[15:8];
      A_FIFO:   rdata = fifo_dout;
      A_SEQ:    rdata = cmd_q;
      A_BUS_LO: rdata = bus_sense[7:0];
      A_BUS_HI: rdata = bus_sense[15:8];
      A_FCOUNT: rdata = 8'(fifo_cnt);
      A_EXC:    rdata = {5'b0, exc_q};
      A_ERR:    rdata = {6'b0, err_q};
      A_MASK:   rdata = {5'b0, mask_q};
      A_ISTAT:  rdata = {5'b0, int_stat};
      A_SRC:    rdata = {5'b0, src_q};
      A_DST:    rdata = {5'b0, dst_q};
      A_SYNC:   rdata = sync_q;
      A_CHIP:   rdata = CHIP_ID;
      default:  rdata = selto_q;
    endcase
  end

  // Assertions
  p_cmd_clears_done_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_wr && !dec.done && !dec.busfree && !seq_done) |=> !int_stat[IS_DONE]);

  p_req_one_cycle_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (seq_req && !cmd_wr) |=> !seq_req);

  p_len_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_wr && (op == OP_DIN || op == OP_DOUT) && cnt_q == 16'h0)
      |=> (seq_req && seq_len == 17'h10000));

  p_busfree_mm_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ev_busfree_mm |=> (exc_q[EX_PHASE] && int_stat[IS_EXC] && ack_release && !seq_req));

  p_srst_r8: assert property (@(posedge clk) disable iff (!rst_n)
    srst_ev |=> (src_q == 3'd7 && cnt_q == 16'h0 && mask_q == 3'b0 &&
                 fifo_cnt == '0 && cmd_q == 8'h0 && int_stat[IS_DONE]));

  p_flush_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_wr && dec.flush) |=> (fifo_cnt == '0 && int_stat[IS_DONE]));

  p_masked_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_q == 3'b0) |-> !irq);

  p_cmd_empty_no_req_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_wr && op == OP_CMD && fifo_empty) |=> !seq_req);
endmodule

// File: tb/scsi_rf_front_test.sv
module scsi_rf_front_test;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH      = 8;
  localparam logic [7:0] CHIP = 8'hC3;
  localparam int WATCHDOG   = 20000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  addr = '0;
  logic        wr_en = 1'b0, rd_en = 1'b0;
  logic [7:0]  wdata = '0;
  logic [7:0]  rdata;
  logic [15:0] bus_sense = '0;
  logic        seq_done = 1'b0, seq_selto = 1'b0, seq_arblost = 1'b0;
  logic        seq_req, seq_atn, seq_dma, dma_req, ack_release, parity_en, resel_en, irq;
  logic [3:0]  seq_op;
  logic [16:0] seq_len;

  always #(CLK_PERIOD/2) clk = ~clk;

  scsi_rf_front #(.FIFO_DEPTH(DEPTH), .CHIP_ID(CHIP)) uut (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .rd_en(rd_en),
    .wdata(wdata), .rdata(rdata), .bus_sense(bus_sense),
    .seq_done(seq_done), .seq_selto(seq_selto), .seq_arblost(seq_arblost),
    .seq_req(seq_req), .seq_op(seq_op), .seq_len(seq_len), .seq_atn(seq_atn),
    .seq_dma(seq_dma), .dma_req(dma_req), .ack_release(ack_release),
    .parity_en(parity_en), .resel_en(resel_en), .irq(irq)
  );

  int n_chk = 0, n_fail = 0;
  bit started = 0;

  // Behavioural reference state
  logic [7:0] m_fifo[$];
  int m_cnt = 0, m_cmd = 0, m_exc = 0, m_err = 0, m_stat = 0, m_mask = 0;
  int m_src = 7, m_dst = 0, m_sync = 2, m_selto = 0, m_par = 0, m_rsl = 0;
  int exp_req, exp_len;

  task automatic check(input string tag, input int act, input int exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
  endtask

  function automatic int exp_reg(input int a);
    case (a)
      0: return m_cnt & 255;
      1: return (m_cnt >> 8) & 255;
      2: return (m_fifo.size() > 0) ? int'(m_fifo[0]) : 0;
      3: return m_cmd;
      4: return int'(bus_sense[7:0]);
      5: return int'(bus_sense[15:8]);
      6: return m_fifo.size();
      7: return m_exc;
      8: return m_err;
      9: return m_mask;
      10: return m_stat;
      11: return m_src;
      12: return m_dst;
      13: return m_sync;
      14: return int'(CHIP);
      default: return m_selto;
    endcase
  endfunction

  task automatic model_cmd(input int d);
    int op;
    op = d & 15;
    exp_req = (op >= 1 && op <= 8 && !(op == 3 && m_fifo.size() == 0)) ? 1 : 0;
    exp_len = ((op == 5 || op == 6) && m_cnt == 0) ? 65536 : m_cnt;
    m_cmd = d;
    m_stat = m_stat & ~1;
    case (op)
      1: m_exc = m_exc & ~4;
      2: m_exc = m_exc & ~1;
      9: if (bus_sense[13]) begin m_exc |= 2; m_stat |= 2; end else m_stat |= 1;
      10: begin m_par = 1; m_stat |= 1; end
      11: begin m_par = 0; m_stat |= 1; end
      12: begin m_rsl = 1; m_stat |= 1; end
      13: begin m_rsl = 0; m_stat |= 1; end
      14: begin
        m_cmd = 0; m_fifo.delete(); m_mask = 0; m_exc = 0; m_err = 0;
        m_cnt = 0; m_src = 7; m_stat |= 1;
      end
      15: begin m_fifo.delete(); m_stat |= 1; end
      default: ;
    endcase
  endtask

  task automatic wr(input int a, input int d);
    int op;
    @(negedge clk);
    addr = 4'(a); wdata = 8'(d); wr_en = 1'b1;
    @(posedge clk); #1;
    wr_en = 1'b0;
    case (a)
      0: m_cnt = (m_cnt & 'hFF00) | (d & 255);
      1: m_cnt = (m_cnt & 'h00FF) | ((d & 255) << 8);
      2: if (m_fifo.size() < DEPTH) m_fifo.push_back(8'(d));
         else begin m_err |= 1; m_stat |= 4; end
      3: begin
        model_cmd(d);
        op = d & 15;
        check("R4 seq_req", int'(seq_req), exp_req);
        check("R7 ack_release", int'(ack_release), (op == 9) ? 1 : 0);
        if (exp_req == 1) begin
          check("R4 seq_op", int'(seq_op), op);
          check("R5 seq_len", int'(seq_len), exp_len);
          check("R4 seq_atn", int'(seq_atn), (op == 2) ? ((d >> 5) & 1) : 0);
          check("R4 seq_dma", int'(seq_dma), (d >> 7) & 1);
          check("R4 dma_req", int'(dma_req), ((op == 5 || op == 6) && d[7]) ? 1 : 0);
        end else begin
          check("R4 dma_req idle", int'(dma_req), 0);
        end
      end
      9: m_mask = d & 7;
      10: m_stat = m_stat & ~(d & 7);
      11: m_src = d & 7;
      12: m_dst = d & 7;
      13: m_sync = d & 255;
      15: m_selto = d & 255;
      default: ;
    endcase
  endtask

  task automatic rd_chk(input int a, input string tag);
    int e;
    e = exp_reg(a);
    @(negedge clk);
    addr = 4'(a); rd_en = 1'b1;
    #1;
    check(tag, int'(rdata), e);
    @(posedge clk); #1;
    rd_en = 1'b0;
    if (a == 2) begin
      if (m_fifo.size() > 0) void'(m_fifo.pop_front());
      else begin m_err |= 2; m_stat |= 4; end
    end
  endtask

  task automatic ev(input bit d, input bit s, input bit a);
    @(negedge clk);
    seq_done = d; seq_selto = s; seq_arblost = a;
    @(posedge clk); #1;
    seq_done = 0; seq_selto = 0; seq_arblost = 0;
    if (d) m_stat |= 1;
    if (s) begin m_exc |= 1; m_stat |= 2; end
    if (a) begin m_exc |= 4; m_stat |= 2; end
  endtask

  // Per-clock comparison of the interrupt line against the model (R10)
  always @(negedge clk) begin
    if (started) check("R10 irq", int'(irq), ((m_stat & m_mask) != 0) ? 1 : 0);
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    summary();
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    started = 1;

    // R1 reset state
    for (int a = 0; a < 16; a++) rd_chk(a, "R1 reset value");
    check("R1 irq after reset", int'(irq), 0);

    // R2 readback
    wr(0, 'h34); wr(1, 'h12); wr(12, 'h05); wr(13, 'h7E); wr(15, 'h99); wr(11, 'h03);
    rd_chk(0, "R2 count low"); rd_chk(1, "R2 count high");
    rd_chk(12, "R2 dst"); rd_chk(13, "R2 sync"); rd_chk(15, "R2 seltimeout"); rd_chk(11, "R2 src");

    // R3 FIFO order, overflow, underflow
    for (int i = 0; i < DEPTH; i++) wr(2, 'hA0 + i);
    rd_chk(6, "R3 full count");
    wr(2, 'hEE);
    rd_chk(6, "R3 count after overflow");
    rd_chk(8, "R3 overflow error bit");
    rd_chk(10, "R3 error interrupt");
    for (int i = 0; i < DEPTH; i++) rd_chk(2, "R3 pop order");
    rd_chk(2, "R3 empty pop reads zero");
    rd_chk(6, "R3 count stays zero");
    rd_chk(8, "R3 underflow error bit");

    // R10 mask and write-1-to-clear
    wr(9, 7);
    check("R10 irq high", int'(irq), 1);
    wr(10, 4);
    rd_chk(10, "R10 w1c");
    check("R10 irq low", int'(irq), 0);

    // R4 / R5 commands
    wr(3, 'h22); rd_chk(3, "R4 command readback"); rd_chk(10, "R4 done cleared");
    wr(3, 'h02);
    wr(3, 'h86);
    wr(0, 0); wr(1, 0);
    wr(3, 'h05);
    wr(3, 'h86);
    wr(3, 'h04); wr(3, 'h07); wr(3, 'h88);
    wr(3, 'h0);

    // R12 command phase needs FIFO data
    wr(3, 'h03);
    wr(2, 'h12); wr(3, 'h03);
    rd_chk(10, "R12 no done");

    // R6 exception handling
    ev(0, 0, 1); rd_chk(7, "R6 arb lost"); rd_chk(10, "R6 exc interrupt");
    wr(3, 'h01); rd_chk(7, "R6 arbitrate clears");
    ev(0, 1, 0); rd_chk(7, "R6 sel timeout");
    wr(3, 'h02); rd_chk(7, "R6 select clears");
    ev(1, 0, 0); rd_chk(10, "R6 seq done");

    // R7 bus-free
    wr(10, 7);
    bus_sense = 16'h2000 | 16'h0041;
    rd_chk(5, "R7 bus status high"); rd_chk(4, "R7 bus status low");
    wr(3, 'h09); rd_chk(7, "R7 phase mismatch"); rd_chk(10, "R7 exc interrupt");
    bus_sense = 16'h0;
    wr(10, 7);
    wr(3, 'h09); rd_chk(10, "R7 done when free");

    // R11 parity / reselect
    wr(3, 'h0A); check("R11 parity on", int'(parity_en), 1);
    wr(3, 'h0C); check("R11 resel on", int'(resel_en), 1);
    wr(3, 'h0B); check("R11 parity off", int'(parity_en), 0);
    wr(3, 'h0D); check("R11 resel off", int'(resel_en), 0);
    rd_chk(10, "R11 done");

    // R9 flush
    wr(2, 1); wr(2, 2); wr(2, 3);
    wr(3, 'h0F); rd_chk(6, "R9 flushed"); rd_chk(10, "R9 done");

    // R8 soft reset
    wr(0, 'h55); wr(11, 2); wr(9, 3); wr(2, 9); wr(2, 7); ev(0, 1, 0);
    wr(3, 'h0E);
    for (int a = 0; a < 16; a++) if (a != 2) rd_chk(a, "R8 after soft reset");

    repeat (2) @(negedge clk);
    started = 0;
    summary();
    $finish;
  end
endmodule